// File: doc/BRIEF.md
# Lookahead Two's-Complement Adder/Subtractor

This block adds or subtracts two two's-complement words of a parameterized width in a single combinational pass, with no clock. A single mode input picks the operation. In subtract mode the second operand is bit-inverted and a carry-in of one is injected at the least significant position. This forms the two's-complement negation within the same addition, so one carry network serves both operations.

The carries are not chained bit to bit. Each carry into position i+1 is computed as one flat OR of products, built from per-bit generate (AND of the operand bits) and propagate (OR of the operand bits) terms. Every product is written directly against the carry-in. The block has three outputs: the result word, the carry out of the top bit, and a signed-overflow flag. The flag is formed by comparing the carry into the top bit with the carry out of it. The default width is 4, so every operand pair can be checked.

Top module: `lookahead_addsub`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (`opnd_a` + `opnd_b`) modulo 2^WIDTH and `carry_out` equals bit WIDTH of the unsigned sum.
- R2: With `sub_mode` = 1, `result` equals (`opnd_a` - `opnd_b`) modulo 2^WIDTH and `carry_out` is 1 exactly when `opnd_a` >= `opnd_b` read as unsigned numbers (no borrow).
- R3: `ovf_flag` is 1 exactly when the true signed result of the selected operation, with both operands read as two's complement, lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R4: At WIDTH 4, adding 0101 and 0011 gives `result` 1000 with `ovf_flag` 1 and `carry_out` 0.
- R5: At WIDTH 4, adding 1011 and 1101 gives `result` 1000 with `ovf_flag` 0 and `carry_out` 1.
- R6: Subtracting zero from any `opnd_a` returns `opnd_a` with `carry_out` 1 and `ovf_flag` 0. Subtracting the most negative value from zero returns the most negative value with `ovf_flag` 1 and `carry_out` 0.
- R7: `carry_out` and `ovf_flag` are independent. All four combinations occur, for example 1000+1000 gives 0000 with both flags set.
- R8: The outputs depend only on the present inputs. With all inputs at zero, `result`, `carry_out` and `ovf_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand (minuend in subtract mode) |
| opnd_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Sum or difference modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the most significant bit |
| ovf_flag | output | 1 | Signed two's-complement overflow |

## Verification
Whenever the inputs settle, the bound checker compares the result and carry against plain integer addition and subtraction. It compares the overflow flag against a sign-based rule that does not use the internal carries. It also checks the two fixed 4-bit examples and the subtract-zero identity. Only the bench sweep can show that every operand pair in both modes is right at once, that all four combinations of carry and overflow actually occur, and that the most-negative-operand corner behaves as required.

// File: rtl/las_pkg.sv
package las_pkg;

    localparam int LAS_DEF_WIDTH = 4;

    typedef enum logic {
        LAS_ADD = 1'b0,
        LAS_SUB = 1'b1
    } las_mode_e;

endpackage

// File: rtl/las_operand_cond.sv
module las_operand_cond
    import las_pkg::*;
#(
    parameter int WIDTH = LAS_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] raw_b,
    input  logic             mode_bit,
    output logic [WIDTH-1:0] eff_b,
    output logic             carry_in
);

    las_mode_e mode;

    assign mode = las_mode_e'(mode_bit);

    always_comb begin
        unique case (mode)
            LAS_ADD: begin
                eff_b    = raw_b;
                carry_in = 1'b0;
            end
            LAS_SUB: begin
                eff_b    = ~raw_b;
                carry_in = 1'b1;
            end
            default: begin
                eff_b    = raw_b;
                carry_in = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/las_gp_gen.sv
module las_gp_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] half_sum
);

    for (genvar bi = 0; bi < WIDTH; bi++) begin : g_bit
        assign gen[bi]      = op_x[bi] & op_y[bi];
        assign prop[bi]     = op_x[bi] | op_y[bi];
        assign half_sum[bi] = op_x[bi] ^ op_y[bi];
    end

endmodule

// File: rtl/las_carry_net.sv
module las_carry_net #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    input  logic             cin,
    output logic [WIDTH:0]   carries
);

    assign carries[0] = cin;

    // Each carry is a flat OR of products; every product is anchored on
    // either one generate bit or the carry-in, never on a lower carry.
    for (genvar ci = 0; ci < WIDTH; ci++) begin : g_carry
        logic sop;

        always_comb begin
            logic prod;
            sop = 1'b0;
            for (int j = 0; j <= ci; j++) begin
                prod = gen[j];
                for (int k = j + 1; k <= ci; k++) begin
                    prod = prod & prop[k];
                end
                sop = sop | prod;
            end
            prod = cin;
            for (int k = 0; k <= ci; k++) begin
                prod = prod & prop[k];
            end
            sop = sop | prod;
        end

        assign carries[ci+1] = sop;
    end

endmodule

// File: rtl/las_sum_ovf.sv
module las_sum_ovf #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] half_sum,
    input  logic [WIDTH:0]   carries,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    for (genvar si = 0; si < WIDTH; si++) begin : g_sum
        assign sum[si] = half_sum[si] ^ carries[si];
    end

    assign cout = carries[WIDTH];
    assign ovf  = carries[WIDTH] ^ carries[WIDTH-1];

endmodule

// File: rtl/lookahead_addsub.sv
module lookahead_addsub
    import las_pkg::*;
#(
    parameter int WIDTH = LAS_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf_flag
);

    logic [WIDTH-1:0] eff_b;
    logic             cin;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] half_sum;
    logic [WIDTH:0]   carries;

    las_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .raw_b    (opnd_b),
        .mode_bit (sub_mode),
        .eff_b    (eff_b),
        .carry_in (cin)
    );

    las_gp_gen #(.WIDTH(WIDTH)) u_gp (
        .op_x     (opnd_a),
        .op_y     (eff_b),
        .gen      (gen),
        .prop     (prop),
        .half_sum (half_sum)
    );

    las_carry_net #(.WIDTH(WIDTH)) u_carry (
        .gen     (gen),
        .prop    (prop),
        .cin     (cin),
        .carries (carries)
    );

    las_sum_ovf #(.WIDTH(WIDTH)) u_sum (
        .half_sum (half_sum),
        .carries  (carries),
        .sum      (result),
        .cout     (carry_out),
        .ovf      (ovf_flag)
    );

endmodule

// File: rtl/las_checker.sv
module las_checker #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             sub_mode,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             ovf_flag
);

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        logic [WIDTH:0]   wide_sum;
        logic [WIDTH-1:0] flip_b;
        logic             same_sign;
        wide_sum  = {1'b0, opnd_a} + {1'b0, opnd_b};
        flip_b    = sub_mode ? ~opnd_b : opnd_b;
        same_sign = (opnd_a[WIDTH-1] == flip_b[WIDTH-1]);
        if (!$isunknown({opnd_a, opnd_b, sub_mode})) begin
            if (!sub_mode) begin
                AST_ADD_SUM: assert ({carry_out, result} == wide_sum); // R1
            end
            if (sub_mode) begin
                AST_SUB_DIFF: assert ((result == WIDTH'(opnd_a - opnd_b)) && (carry_out == (opnd_a >= opnd_b))); // R2
            end
            AST_OVF_SIGN: assert (ovf_flag == (same_sign && (result[WIDTH-1] != opnd_a[WIDTH-1]))); // R3
            if (WIDTH == 4 && !sub_mode && opnd_a == WIDTH'(5) && opnd_b == WIDTH'(3)) begin
                AST_POS_WRAP: assert (result == MOST_NEG && ovf_flag && !carry_out); // R4
            end
            if (WIDTH == 4 && !sub_mode && opnd_a == WIDTH'(11) && opnd_b == WIDTH'(13)) begin
                AST_NEG_NO_OVF: assert (result == MOST_NEG && !ovf_flag && carry_out); // R5
            end
            if (sub_mode && opnd_b == '0) begin
                AST_SUB_ZERO: assert (result == opnd_a && carry_out && !ovf_flag); // R6
            end
        end
    end

endmodule

bind lookahead_addsub las_checker #(.WIDTH(WIDTH)) u_las_checker (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .sub_mode  (sub_mode),
    .result    (result),
    .carry_out (carry_out),
    .ovf_flag  (ovf_flag)
);

// File: tb/test_lookahead_addsub.sv
module test_lookahead_addsub;

    localparam int W    = 4;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         sub_mode = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit seen_c1_o0 = 0, seen_c0_o1 = 0, seen_c1_o1 = 0, seen_c0_o0 = 0;

    always #2 clk = ~clk;

    lookahead_addsub #(.WIDTH(W)) i_lookahead_addsub (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .sub_mode  (sub_mode),
        .result    (result),
        .carry_out (carry_out),
        .ovf_flag  (ovf_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input bit m);
        @(posedge clk);
        opnd_a   = W'(a);
        opnd_b   = W'(b);
        sub_mode = m;
        @(negedge clk);
    endtask

    function automatic int to_signed(input int v);
        return (v >= SPAN / 2) ? v - SPAN : v;
    endfunction

    task automatic check_vector(input int a, input int b, input bit m);
        int us, exp_res, exp_cy, sv, exp_ov;
        string req;
        apply(a, b, m);
        if (!m) begin
            us  = a + b;
            req = "R1";
            sv  = to_signed(a) + to_signed(b);
        end else begin
            us  = a + ((~b) & (SPAN - 1)) + 1;
            req = "R2";
            sv  = to_signed(a) - to_signed(b);
        end
        exp_res = us % SPAN;
        exp_cy  = us / SPAN;
        exp_ov  = (sv > SPAN / 2 - 1 || sv < -(SPAN / 2)) ? 1 : 0;
        check(req, "result", int'(result), exp_res);
        check(req, "carry_out", int'(carry_out), exp_cy);
        check("R3", "ovf_flag", int'(ovf_flag), exp_ov);
        if (carry_out && !ovf_flag)  seen_c1_o0 = 1;
        if (!carry_out && ovf_flag)  seen_c0_o1 = 1;
        if (carry_out && ovf_flag)   seen_c1_o1 = 1;
        if (!carry_out && !ovf_flag) seen_c0_o0 = 1;
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: all-zero inputs give all-zero outputs
        check("R8", "result", int'(result), 0);
        check("R8", "carry_out", int'(carry_out), 0);
        check("R8", "ovf_flag", int'(ovf_flag), 0);

        // R4
        apply(5, 3, 1'b0);
        check("R4", "result", int'(result), 8);
        check("R4", "ovf_flag", int'(ovf_flag), 1);
        check("R4", "carry_out", int'(carry_out), 0);
        // R5
        apply(11, 13, 1'b0);
        check("R5", "result", int'(result), 8);
        check("R5", "ovf_flag", int'(ovf_flag), 0);
        check("R5", "carry_out", int'(carry_out), 1);
        // R6: subtract zero, and zero minus most negative
        apply(6, 0, 1'b1);
        check("R6", "result", int'(result), 6);
        check("R6", "carry_out", int'(carry_out), 1);
        check("R6", "ovf_flag", int'(ovf_flag), 0);
        apply(0, SPAN / 2, 1'b1);
        check("R6", "result", int'(result), SPAN / 2);
        check("R6", "ovf_flag", int'(ovf_flag), 1);
        check("R6", "carry_out", int'(carry_out), 0);
        // R7: both flags set on most negative plus itself
        apply(SPAN / 2, SPAN / 2, 1'b0);
        check("R7", "result", int'(result), 0);
        check("R7", "carry_out", int'(carry_out), 1);
        check("R7", "ovf_flag", int'(ovf_flag), 1);

        // R1, R2, R3: exhaustive sweep in both modes
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < SPAN; a++) begin
                for (int b = 0; b < SPAN; b++) begin
                    check_vector(a, b, m[0]);
                end
            end
        end

        // R7: every carry/overflow combination was observed
        check("R7", "carry1_ovf0 seen", int'(seen_c1_o0), 1);
        check("R7", "carry0_ovf1 seen", int'(seen_c0_o1), 1);
        check("R7", "carry1_ovf1 seen", int'(seen_c1_o1), 1);
        check("R7", "carry0_ovf0 seen", int'(seen_c0_o0), 1);

        // R8: back to zero inputs after activity
        apply(0, 0, 1'b0);
        check("R8", "result after sweep", int'(result), 0);
        check("R8", "flags after sweep", int'({carry_out, ovf_flag}), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule